// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

This block pairs a 16-bit free-running counter with two independent compare channels. The counter advances once per timer tick. A tick comes either from dividing the system clock by 4, 8 or 16, or from the rising edges of an external clock input, which is synchronised first. On every tick each channel compares the counter with its 16-bit compare value. On a match the channel sets a status flag. If its output is enabled, it also loads a programmed level into its output pin latch. An interrupt line is raised while any flag is set and both interrupt control bits are on.

Software reaches the block over a byte-wide register bus with eight addresses. Each compare value is written as a high byte and a low byte. Writing the high byte suspends that channel's comparison until the low byte arrives, so a half-updated value never produces a match. A flag is cleared in two steps. First a status read must see the flag set. Then any read or write of that channel's low compare byte clears it. A match that lands in the same cycle as that access wins, and the flag stays set.

Register map (bus_addr): 0 = control A (bits 1:0 tick source, bit 2 channel-1 output enable, bit 3 channel-2 output enable). 1 = control B (bit 0 channel-1 level, bit 1 channel-2 level, bit 2 interrupt enable, bit 3 interrupt route). 2 = status (bit 0 channel-1 flag, bit 1 channel-2 flag). 3/4 = channel-1 compare high/low. 5/6 = channel-2 compare high/low. 7 reads zero. Control registers keep 4 bits and read back zero above them.

Top module: `oc_dual_timer`

## Requirements
- R1: Both compare values reset to 8000h. The high byte sits at address 3 (channel 1) or 5 (channel 2) and the low byte at 4 or 6. Each byte reads back what was last written, and no match ever alters a compare value.
- R2: Control A bits 1:0 select the tick source: 00 divides the clock by 4, 01 by 8, 10 by 16. 11 gives one tick per rising edge of `ext_tclk`, after a two-flop synchroniser.
- R3: The counter is 16 bits wide, starts at 0 after reset, advances by one on each tick and wraps from FFFFh to 0000h. A given counter value therefore recurs every 65536 ticks.
- R4: When a tick occurs while the counter equals a channel's compare value, that channel's status bit is set (bit 0 for channel 1, bit 1 for channel 2). The bit is visible from the next cycle. Status bits 7:2 read 0.
- R5: A write to a channel's high compare byte inhibits matches on that channel until its low compare byte is written.
- R6: A flag clears only on a read or write of its channel's low compare byte that follows a status read which saw that flag set. A status read that saw the flag clear does not arm the clear. An access to the other channel's low byte does not clear it. A match in the same cycle as the clearing access keeps the flag set.
- R7: Both pin latches are 0 after reset. On a match with the channel's output enable set, the latch takes the channel's level bit. Otherwise the latch holds, and a match with the enable clear still sets the flag. `cmp_pin_oe` mirrors the two enable bits.
- R8: `irq` is 1 exactly when control B bits 2 and 3 are both set and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ext_tclk | input | 1 | External timer clock, asynchronous |
| cmp_pin | output | 2 | Output latches, bit 0 channel 1 |
| cmp_pin_oe | output | 2 | Output enables, bit 0 channel 1 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clearing access to a low compare byte that falls in exactly the same cycle as a new match on an armed flag. The bench steers into it from its own reference model: it waits for the negative edge at which the modelled counter equals the compare value and the modelled prescaler is about to tick, and issues the low-byte read in that cycle. The 65536-tick wrap is reached by running the external tick source at its fastest rate and timing two successive matches on one unchanged compare value.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int CMP_W  = 16;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 4;
  localparam int CTL_W  = 4;
  localparam logic [CMP_W-1:0] CMP_RST = 16'h8000;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTLA = 3'd0,
    RA_CTLB = 3'd1,
    RA_STAT = 3'd2,
    RA_C1HI = 3'd3,
    RA_C1LO = 3'd4,
    RA_C2HI = 3'd5,
    RA_C2LO = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    CK_DIV4  = 2'd0,
    CK_DIV8  = 2'd1,
    CK_DIV16 = 2'd2,
    CK_EXT   = 2'd3
  } clk_sel_e;

  // terminal count of the divider: divide ratio minus one
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    return PRE_W'((32'd4 << sel) - 32'd1);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
    return ADDR_W'(32'd3 + 32'd2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
    return ADDR_W'(32'd4 + 32'd2 * ch);
  endfunction
endpackage

// File: rtl/oc_prescaler.sv
module oc_prescaler
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       ext_in,
  output logic       tick
);
  logic [PRE_W-1:0] div_cnt;
  logic [2:0]       ext_sync;
  logic             ext_mode;
  logic [PRE_W-1:0] lim;

  assign ext_mode = (clk_sel_e'(sel) == CK_EXT);
  assign lim      = pre_limit(sel);
  assign tick     = ext_mode ? (ext_sync[1] & ~ext_sync[2]) : (div_cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      ext_sync <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_in};
      if (ext_mode || div_cnt >= lim) div_cnt <= '0;
      else                            div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int               W       = 16,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hi_wr,
  input  logic         lo_wr,
  input  logic         lo_acc,
  input  logic         stat_rd,
  input  logic [7:0]   wdata,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         oe,
  input  logic         lvl,
  output logic [W-1:0] cmp,
  output logic         flag,
  output logic         arm,
  output logic         pin,
  output logic         match_evt
);
  localparam int HB = W - 8;

  logic inhib;

  assign match_evt = tick & ~inhib & (count == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp   <= RST_VAL;
      inhib <= 1'b0;
      flag  <= 1'b0;
      arm   <= 1'b0;
      pin   <= 1'b0;
    end else begin
      if (hi_wr) begin
        cmp[W-1:8] <= HB'(wdata);
        inhib      <= 1'b1;
      end
      if (lo_wr) begin
        cmp[7:0] <= wdata;
        inhib    <= 1'b0;
      end
      // a match beats the clearing access
      if (match_evt)         flag <= 1'b1;
      else if (lo_acc && arm) flag <= 1'b0;
      if (lo_acc)               arm <= 1'b0;
      else if (stat_rd && flag) arm <= 1'b1;
      if (match_evt && oe) pin <= lvl;
    end
  end
endmodule

// File: rtl/oc_dual_timer.sv
module oc_dual_timer
  import oc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ext_tclk,
  output logic [NCH-1:0]    cmp_pin,
  output logic [NCH-1:0]    cmp_pin_oe,
  output logic              irq
);
  logic [CTL_W-1:0]          ctla_q, ctlb_q;
  logic                      tick_w;
  logic [CMP_W-1:0]          count_w;
  logic [NCH-1:0][CMP_W-1:0] cmp_w;
  logic [NCH-1:0]            flag_w, arm_w, match_w, hi_wr_w, lo_wr_w, lo_acc_w;
  logic [NCH-1:0]            oe_w, lvl_w;
  logic                      stat_rd_w;

  assign oe_w      = ctla_q[3:2];
  assign lvl_w     = ctlb_q[1:0];
  assign stat_rd_w = bus_rd && (bus_addr == RA_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctla_q <= '0;
      ctlb_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == RA_CTLA) ctla_q <= bus_wdata[CTL_W-1:0];
      if (bus_addr == RA_CTLB) ctlb_q <= bus_wdata[CTL_W-1:0];
    end
  end

  oc_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .sel(ctla_q[1:0]), .ext_in(ext_tclk), .tick(tick_w)
  );

  oc_counter #(.W(CMP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .count(count_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hi_wr_w[i]  = bus_wr && (bus_addr == hi_addr(i));
    assign lo_wr_w[i]  = bus_wr && (bus_addr == lo_addr(i));
    assign lo_acc_w[i] = (bus_wr || bus_rd) && (bus_addr == lo_addr(i));

    oc_channel #(.W(CMP_W), .RST_VAL(CMP_RST)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .hi_wr(hi_wr_w[i]), .lo_wr(lo_wr_w[i]), .lo_acc(lo_acc_w[i]),
      .stat_rd(stat_rd_w), .wdata(bus_wdata),
      .tick(tick_w), .count(count_w),
      .oe(oe_w[i]), .lvl(lvl_w[i]),
      .cmp(cmp_w[i]), .flag(flag_w[i]), .arm(arm_w[i]),
      .pin(cmp_pin[i]), .match_evt(match_w[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_addr_e'(bus_addr))
      RA_CTLA: bus_rdata = 8'(ctla_q);
      RA_CTLB: bus_rdata = 8'(ctlb_q);
      RA_STAT: bus_rdata = 8'(flag_w);
      RA_C1HI: bus_rdata = cmp_w[0][CMP_W-1:8];
      RA_C1LO: bus_rdata = cmp_w[0][7:0];
      RA_C2HI: bus_rdata = cmp_w[1][CMP_W-1:8];
      RA_C2LO: bus_rdata = cmp_w[1][7:0];
      default: bus_rdata = '0;
    endcase
  end

  assign cmp_pin_oe = oe_w;
  assign irq        = ctlb_q[2] & ctlb_q[3] & (|flag_w);
endmodule

// File: rtl/oc_dual_timer_chk.sv
module oc_dual_timer_chk
  import oc_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic [CMP_W-1:0]          count,
  input logic [NCH-1:0][CMP_W-1:0] cmp,
  input logic [NCH-1:0]            flag,
  input logic [NCH-1:0]            arm,
  input logic [NCH-1:0]            match,
  input logic [NCH-1:0]            hi_wr,
  input logic [NCH-1:0]            lo_wr,
  input logic [NCH-1:0]            lo_acc,
  input logic [NCH-1:0]            oe,
  input logic [NCH-1:0]            pin,
  input logic                      irq
);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + 16'd1);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flag));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R1
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_wr[i] || lo_wr[i]) |=> $stable(cmp[i]));
    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(match[i]));
    // R5
    inhib_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr[i] |=> !match[i]);
    // R6
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(lo_acc[i] && arm[i]));
    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match[i] |=> flag[i]);
    // R7
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(match[i] && oe[i]) |=> $stable(pin[i]));
  end
endmodule

bind oc_dual_timer oc_dual_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .count(count_w), .cmp(cmp_w),
  .flag(flag_w), .arm(arm_w), .match(match_w), .hi_wr(hi_wr_w),
  .lo_wr(lo_wr_w), .lo_acc(lo_acc_w), .oe(oe_w), .pin(cmp_pin), .irq(irq)
);

// File: tb/oc_dual_timer_tb.sv
`timescale 1ns/1ps
module oc_dual_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd7;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_tclk = 1'b0;
  logic [1:0] cmp_pin, cmp_pin_oe;
  logic       irq;

  always #2.5 clk = ~clk;

  oc_dual_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tclk(ext_tclk),
    .cmp_pin(cmp_pin), .cmp_pin_oe(cmp_pin_oe), .irq(irq)
  );

  int  n_chk = 0, n_err = 0;
  bit  done = 0;
  longint cyc = 0;
  int  ext_half = 0, ext_ph = 0;

  // reference model state
  int m_cmp[2], m_inh[2], m_flg[2], m_arm[2], m_pin[2];
  int m_ca, m_cb, m_pc, m_cnt, e1, e2, e3;

  function automatic int blim(int s);
    return (4 << s) - 1;
  endfunction

  function automatic int m_rdata(int a);
    case (a)
      0: return m_ca;
      1: return m_cb;
      2: return m_flg[0] + 2 * m_flg[1];
      3: return m_cmp[0] >> 8;
      4: return m_cmp[0] & 255;
      5: return m_cmp[1] >> 8;
      6: return m_cmp[1] & 255;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cmp[i] = 'h8000; m_inh[i] = 0; m_flg[i] = 0; m_arm[i] = 0; m_pin[i] = 0;
      end
      m_ca = 0; m_cb = 0; m_pc = 0; m_cnt = 0; e1 = 0; e2 = 0; e3 = 0;
    end else begin
      int sel, tk, hit[2], lacc, srd, nf, na;
      sel = m_ca & 3;
      tk  = (sel == 3) ? (e2 && !e3) : (m_pc >= blim(sel));
      srd = bus_rd && bus_addr == 2;
      for (int i = 0; i < 2; i++) begin
        hit[i] = tk && !m_inh[i] && (m_cnt == m_cmp[i]);
        lacc = (bus_rd || bus_wr) && bus_addr == 4 + 2 * i;
        nf = hit[i] ? 1 : ((lacc && m_arm[i]) ? 0 : m_flg[i]);
        na = lacc ? 0 : ((srd && m_flg[i]) ? 1 : m_arm[i]);
        m_flg[i] = nf; m_arm[i] = na;
        if (hit[i] && ((m_ca >> (2 + i)) & 1)) m_pin[i] = (m_cb >> i) & 1;
        if (bus_wr && bus_addr == 3 + 2 * i) begin
          m_cmp[i] = (m_cmp[i] & 255) | (bus_wdata << 8); m_inh[i] = 1;
        end
        if (bus_wr && bus_addr == 4 + 2 * i) begin
          m_cmp[i] = (m_cmp[i] & 'hFF00) | bus_wdata; m_inh[i] = 0;
        end
      end
      if (sel == 3 || m_pc >= blim(sel)) m_pc = 0; else m_pc = m_pc + 1;
      m_cnt = (m_cnt + tk) & 'hFFFF;
      e3 = e2; e2 = e1; e1 = ext_tclk;
      if (bus_wr && bus_addr == 0) m_ca = bus_wdata & 15;
      if (bus_wr && bus_addr == 1) m_cb = bus_wdata & 15;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ex_irq;
      ex_irq = ((m_cb >> 2) & 1) && ((m_cb >> 3) & 1) && (m_flg[0] || m_flg[1]);
      n_chk++;
      if (bus_rdata !== 8'(m_rdata(bus_addr)) || cmp_pin !== 2'(m_pin[0] + 2 * m_pin[1])
          || cmp_pin_oe !== 2'(m_ca >> 2) || irq !== 1'(ex_irq)) begin
        n_err++;
        $display("FAIL R4/R7/R8 model t=%0t act rd=%h pin=%b oe=%b irq=%b exp rd=%h pin=%0d%0d oe=%0d irq=%0d",
                 $time, bus_rdata, cmp_pin, cmp_pin_oe, irq, m_rdata(bus_addr),
                 m_pin[1], m_pin[0], m_ca >> 2, ex_irq);
      end
    end
  end

  // external clock generator
  always @(negedge clk) begin
    if (ext_half > 0) begin
      ext_ph++;
      if (ext_ph >= ext_half) begin
        ext_ph = 0;
        #1 ext_tclk = ~ext_tclk;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_addr = 3'd7;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); #1;
    bus_addr = 3'(a); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); #1;
    bus_rd = 1'b0; bus_addr = 3'd7;
  endtask

  task automatic set_cmp(input int ch, input int v);
    wr(3 + 2 * ch, (v >> 8) & 255);
    wr(4 + 2 * ch, v & 255);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pin(input int ch, input bit lv, output longint stamp);
    int n = 0;
    while (cmp_pin[ch] !== lv && n < 150000) begin @(negedge clk); n++; end
    stamp = cyc;
  endtask

  task automatic clr_flags();
    int d;
    rd(2, d); rd(4, d); rd(6, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int d;
    longint t0, t1;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(3, d); chk("R1 reset c1 hi", d, 'h80);
    rd(4, d); chk("R1 reset c1 lo", d, 'h00);
    rd(5, d); chk("R1 reset c2 hi", d, 'h80);
    rd(6, d); chk("R1 reset c2 lo", d, 'h00);
    rd(2, d); chk("R4 reset status", d, 0);
    chk("R7 reset pins", cmp_pin, 0);
    chk("R8 reset irq", irq, 0);

    // readback
    set_cmp(0, 'h1234); set_cmp(1, 'hA5C3);
    rd(3, d); chk("R1 c1 hi readback", d, 'h12);
    rd(4, d); chk("R1 c1 lo readback", d, 'h34);
    rd(6, d); chk("R1 c2 lo readback", d, 'hC3);
    clr_flags();

    // flag with output disabled; interrupt gating
    wr(1, 'h4);
    set_cmp(0, (m_cnt + 6) & 'hFFFF);
    idle(40);
    chk("R7 pin held with enable clear", cmp_pin[0], 0);
    chk("R8 irq off with route clear", irq, 0);
    wr(1, 'h8); idle(2);
    chk("R8 irq off with enable clear", irq, 0);
    wr(1, 'hC); idle(2);
    chk("R8 irq on with both set", irq, 1);
    rd(2, d); chk("R4 ch1 status bit0", d, 1);
    rd(4, d); idle(2);
    chk("R6 cleared after status read then lo read", irq, 0);
    rd(3, d); chk("R1 compare unchanged by match", d, (m_cmp[0] >> 8));

    // channel 2 flag
    set_cmp(1, (m_cnt + 6) & 'hFFFF);
    idle(40);
    rd(6, d);
    rd(2, d); chk("R4 ch2 status bit1 / R6 no clear without status read", d, 2);
    rd(4, d); idle(2);
    chk("R6 other channel access keeps flag", irq, 1);
    rd(6, d); idle(2);
    chk("R6 armed lo read clears ch2", irq, 0);

    // status read with flag clear does not arm
    rd(2, d);
    set_cmp(0, (m_cnt + 6) & 'hFFFF);
    idle(40);
    chk("R4 ch1 match raises irq", irq, 1);
    rd(4, d); idle(2);
    chk("R6 unarmed lo read keeps flag", irq, 1);

    // match in the same cycle as the clearing access
    begin
      int v, n;
      v = (m_cnt + 20) & 'hFFFF;
      set_cmp(0, v);
      rd(2, d);
      n = 0;
      while (!(m_cnt == v && m_pc == 3) && n < 1000) begin @(negedge clk); n++; end
      #1 bus_addr = 3'd4; bus_rd = 1'b1;
      @(negedge clk); #1 bus_rd = 1'b0; bus_addr = 3'd7;
      idle(1);
      chk("R6 match beats clearing access", irq, 1);
      rd(2, d); chk("R6 flag still set after collision", d, 1);
      rd(4, d); rd(2, d); chk("R6 later armed access clears", d, 0);
    end

    // high-byte interlock
    begin
      int v, n;
      clr_flags();
      v = (m_cnt + 30) & 'hFFFF;
      set_cmp(0, v);
      wr(3, (v >> 8) & 255);
      n = 0;
      while (m_cnt != ((v + 3) & 'hFFFF) && n < 1000) begin @(negedge clk); n++; end
      rd(2, d); chk("R5 no match while inhibited", d & 1, 0);
      set_cmp(0, (m_cnt + 10) & 'hFFFF);
      idle(60);
      rd(2, d); chk("R5 match after lo write", d & 1, 1);
    end

    // pins: bring both low, level change alone does not move them
    wr(0, 'hC); wr(1, 'h0);
    set_cmp(0, (m_cnt + 8) & 'hFFFF); set_cmp(1, (m_cnt + 8) & 'hFFFF);
    idle(60);
    chk("R7 oe output mirrors enables", cmp_pin_oe, 3);
    wr(1, 'h3); idle(10);
    chk("R7 level change without match holds pins", cmp_pin, 0);

    // tick spacing per source
    for (int s = 0; s < 4; s++) begin
      int lv, v, per;
      lv  = (s % 2 == 0) ? 1 : 0;
      per = (s == 3) ? 6 : (4 << s);
      if (s == 3) ext_half = 3;
      wr(0, 'hC | s);
      wr(1, lv * 3);
      v = (m_cnt + 8) & 'hFFFF;
      set_cmp(0, v); set_cmp(1, (v + 1) & 'hFFFF);
      wait_pin(0, lv[0], t0);
      wait_pin(1, lv[0], t1);
      chk($sformatf("R2 tick period sel=%0d", s), t1 - t0, per);
      chk($sformatf("R7 pins at level sel=%0d", s), cmp_pin, lv * 3);
    end

    // counter wrap: same compare value hit again after 65536 ticks
    ext_half = 1;
    idle(4);
    wr(1, 'h1);
    set_cmp(0, (m_cnt + 8) & 'hFFFF);
    wait_pin(0, 1'b1, t0);
    wr(1, 'h0);
    wait_pin(0, 1'b0, t1);
    chk("R3 wrap period in cycles", t1 - t0, 65536 * 2);
    chk("R2 external edges still ticking", m_cnt != 0, 1);

    finish_run();
  end
endmodule